// File: doc/BRIEF.md
# Inter-Processor Word Mailbox

This block lets a local processor and a remote agent exchange 32-bit words through two independent queues of eight words each. The local processor sees a small register bus. A write to one register places a word on the outbound queue. A read from another register removes the oldest word from the inbound queue. The remote agent feeds the inbound queue and drains the outbound queue through valid/ready word ports.

Software can read empty/full status and the fill level of each queue. It can program a fill threshold for each direction, flush either queue, and raise any interrupt on demand for testing. Three sticky interrupt sources exist:

- outbound level at or below its threshold;
- inbound level above its threshold;
- a misuse error.

Each interrupt source is cleared by writing a one to its bit. Each source is gated by its own enable bit.

Register word offsets (byte address): 0x00 interrupt state, 0x04 interrupt enable, 0x08 interrupt test, 0x0C outbound data (write), 0x10 inbound data (read), 0x14 status, 0x18 error (read), 0x1C outbound threshold, 0x20 inbound threshold, 0x24 flush control (write), 0x28 inbound level (read), 0x2C outbound level (read). In all three interrupt registers, bit 0 is the outbound-threshold source, bit 1 is the inbound-threshold source and bit 2 is the error source.

Top module: `mbx_mailbox`

## Requirements
- R1: While reset is held, interrupt state, interrupt enable and both thresholds read 0, the outputs in `irq_o` are 0, both queues are empty, and status reads 0x5.
- R2: Each write to 0x0C queues one word. The remote side receives the words in write order on `out_data` while `out_valid` is high. 0x2C reads the outbound level (0..8).
- R3: A word offered with `in_valid` is accepted when `in_ready` is high. `in_ready` is low while the inbound queue holds 8 words. Reads of 0x10 return the words in arrival order, and 0x28 reads the inbound level.
- R4: Status bit 0 is set when the inbound queue is empty, and bit 1 is set when the outbound queue is full. Bit 2 equals (outbound level <= outbound threshold), and bit 3 equals (inbound level > inbound threshold).
- R5: Interrupt state bit 0 becomes 1 one cycle after any cycle in which the outbound level is at or below the outbound threshold. A threshold of 0 is valid.
- R6: Interrupt state bit 1 becomes 1 one cycle after any cycle in which the inbound level is above the inbound threshold.
- R7: Writing 1 to an interrupt state bit clears it. If that bit's set condition holds in the same cycle, the bit stays 1.
- R8: A write to 0x0C while the outbound queue is full drops the word and leaves the level at 8. It sets error bit 0 and interrupt state bit 2.
- R9: A read of 0x10 while the inbound queue is empty returns 0. It sets error bit 1 and interrupt state bit 2. Error bits clear when interrupt state bit 2 is cleared by a write of 1.
- R10: Writing 1 to a bit of 0x08 sets the matching interrupt state bit. 0x08 reads 0.
- R11: Each bit of `irq_o` is the AND of the matching interrupt state bit and enable bit.
- R12: Writing 1 to control bit 0 empties the outbound queue, and writing 1 to bit 1 empties the inbound queue, both in one cycle. During an inbound flush cycle `in_ready` is low, so no remote word is taken.
- R13: Reads of 0x0C, 0x24 and unmapped offsets return 0. Writes to read-only registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| in_valid | input | 1 | Remote offers an inbound word |
| in_data | input | 32 | Inbound word |
| in_ready | output | 1 | Inbound word taken this cycle if valid |
| out_valid | output | 1 | Outbound word available |
| out_data | output | 32 | Oldest outbound word |
| out_ready | input | 1 | Remote takes the outbound word |
| irq_o | output | 3 | Interrupts: outbound threshold, inbound threshold, error |

## Verification
Two pairs of events can fall in the same cycle, and both need a directed check.

The first pair is a local read of an empty inbound queue together with a remote word arriving. The bench raises `in_valid` in the same cycle as the read of 0x10. It expects read data 0 and error bit 1 set, and it still expects the inbound level to read 1 afterwards.

The second pair is an inbound flush together with a remote offer. The bench expects `in_ready` to be low in that cycle and the inbound level to read 0 afterwards.

The threshold comparisons are swept over every level from 0 to 8 against every threshold from 0 to 8.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int REG_AW = 6;
    localparam int NIRQ   = 3;
    localparam int IRQ_TXT = 0;
    localparam int IRQ_RXT = 1;
    localparam int IRQ_ERR = 2;

    typedef enum logic [3:0] {
        RI_ISTATE = 4'h0,
        RI_IEN    = 4'h1,
        RI_ITEST  = 4'h2,
        RI_TXDATA = 4'h3,
        RI_RXDATA = 4'h4,
        RI_STATUS = 4'h5,
        RI_ERROR  = 4'h6,
        RI_TXTHR  = 4'h7,
        RI_RXTHR  = 4'h8,
        RI_CTRL   = 4'h9,
        RI_RXLVL  = 4'hA,
        RI_TXLVL  = 4'hB
    } reg_idx_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [DW-1:0]                wdata_i,
    output logic [DW-1:0]                rdata_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic                         empty_o,
    output logic                         full_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign cnt_o   = cnt_q;
    assign rdata_o = mem_q[rptr_q];
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= ptr_inc(wptr_q);
            if (do_pop)  rptr_q <= ptr_inc(rptr_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wptr_q] <= wdata_i;
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] state_o,
    output logic [N-1:0] irq_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~clr_i[g]) | set_i[g];
        end
        assign state_o[g] = bit_q;
        assign irq_o[g]   = bit_q & en_i[g];
    end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    input  logic              out_ready,
    output logic [NIRQ-1:0]   irq_o
);
    localparam int CW = $clog2(DEPTH+1);

    logic [3:0]      widx;
    logic            wr_en, rd_en;
    logic            tx_push_req, rx_pop_req, tx_flush, rx_flush;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]   out_cnt, in_cnt;
    logic [DW-1:0]   rx_head;
    logic            ovf, udf, tx_at_thr, rx_over_thr;
    logic [NIRQ-1:0] ien_q, istate_q, irq_set, irq_clr, test_pulse;
    logic [CW-1:0]   wthr_q, rthr_q;
    logic [1:0]      err_q;

    assign widx  = bus_addr[REG_AW-1:2];
    assign wr_en = bus_req && bus_we;
    assign rd_en = bus_req && !bus_we;

    assign tx_push_req = wr_en && (widx == RI_TXDATA);
    assign rx_pop_req  = rd_en && (widx == RI_RXDATA);
    assign tx_flush    = wr_en && (widx == RI_CTRL) && bus_wdata[0];
    assign rx_flush    = wr_en && (widx == RI_CTRL) && bus_wdata[1];

    assign ovf = tx_push_req && tx_full;
    assign udf = rx_pop_req && rx_empty;

    assign out_valid = !tx_empty;
    assign in_ready  = !rx_full && !rx_flush;

    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush_i(tx_flush),
        .push_i(tx_push_req), .pop_i(out_ready),
        .wdata_i(bus_wdata), .rdata_o(out_data), .cnt_o(out_cnt),
        .empty_o(tx_empty), .full_o(tx_full)
    );

    mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush_i(rx_flush),
        .push_i(in_valid && in_ready), .pop_i(rx_pop_req),
        .wdata_i(in_data), .rdata_o(rx_head), .cnt_o(in_cnt),
        .empty_o(rx_empty), .full_o(rx_full)
    );

    assign tx_at_thr   = (out_cnt <= wthr_q);
    assign rx_over_thr = (in_cnt > rthr_q);

    assign test_pulse = (wr_en && widx == RI_ITEST)  ? bus_wdata[NIRQ-1:0] : '0;
    assign irq_clr    = (wr_en && widx == RI_ISTATE) ? bus_wdata[NIRQ-1:0] : '0;

    always_comb begin
        irq_set          = test_pulse;
        irq_set[IRQ_TXT] = irq_set[IRQ_TXT] | tx_at_thr;
        irq_set[IRQ_RXT] = irq_set[IRQ_RXT] | rx_over_thr;
        irq_set[IRQ_ERR] = irq_set[IRQ_ERR] | ovf | udf;
    end

    mbx_irq #(.N(NIRQ)) irq_i (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr),
        .en_i(ien_q), .state_o(istate_q), .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wthr_q <= '0;
            rthr_q <= '0;
            err_q  <= '0;
        end else begin
            if (wr_en && widx == RI_IEN)   ien_q  <= bus_wdata[NIRQ-1:0];
            if (wr_en && widx == RI_TXTHR) wthr_q <= bus_wdata[CW-1:0];
            if (wr_en && widx == RI_RXTHR) rthr_q <= bus_wdata[CW-1:0];
            if (irq_clr[IRQ_ERR]) err_q <= {udf, ovf};
            else                  err_q <= err_q | {udf, ovf};
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (widx)
                RI_ISTATE: bus_rdata = DW'(istate_q);
                RI_IEN:    bus_rdata = DW'(ien_q);
                RI_RXDATA: bus_rdata = rx_empty ? '0 : rx_head;
                RI_STATUS: bus_rdata = DW'({rx_over_thr, tx_at_thr, tx_full, rx_empty});
                RI_ERROR:  bus_rdata = DW'(err_q);
                RI_TXTHR:  bus_rdata = DW'(wthr_q);
                RI_RXTHR:  bus_rdata = DW'(rthr_q);
                RI_RXLVL:  bus_rdata = DW'(in_cnt);
                RI_TXLVL:  bus_rdata = DW'(out_cnt);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [NIRQ-1:0]   irq_o,
    input logic [CW-1:0]     out_cnt,
    input logic [CW-1:0]     in_cnt,
    input logic [CW-1:0]     rthr_q,
    input logic [NIRQ-1:0]   istate_q
);
    logic [3:0] cidx;
    logic       cwr, crd;
    assign cidx = bus_addr[REG_AW-1:2];
    assign cwr  = bus_req && bus_we;
    assign crd  = bus_req && !bus_we;

    AST_OUT_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) out_cnt <= CW'(DEPTH)); // R2
    AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) (out_cnt == '0) |-> !out_valid); // R2
    AST_IN_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n) (in_cnt == CW'(DEPTH)) |-> !in_ready); // R3
    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == RI_TXDATA && out_cnt == CW'(DEPTH) && !(out_valid && out_ready)) |=> (out_cnt == CW'(DEPTH))); // R8
    AST_UDF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (crd && cidx == RI_RXDATA && in_cnt == '0) |=> istate_q[IRQ_ERR]); // R9
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == RI_ISTATE && bus_wdata[IRQ_RXT] && in_cnt <= rthr_q) |=> !istate_q[IRQ_RXT]); // R7
    AST_FLUSH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == RI_CTRL && bus_wdata[0]) |=> (out_cnt == '0)); // R12
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) (irq_o & ~istate_q) == '0); // R11
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .irq_o(irq_o),
    .out_cnt(out_cnt), .in_cnt(in_cnt), .rthr_q(rthr_q), .istate_q(istate_q)
);

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_mailbox_tb_top;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0, out_data;
    logic        out_valid, out_ready = 1'b0;
    logic [2:0]  irq_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mbx_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic rpush(input logic [31:0] d, output logic acc);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        #1 acc = in_ready;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic rpull(input string req, input logic [31:0] exp);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(req, {31'b0, out_valid}, 32'h1);
        check(req, out_data, exp);
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic acc;

        // R1 reset values
        rd(6'h00, r); check("R1 istate", r, 0);
        rd(6'h04, r); check("R1 ien", r, 0);
        rd(6'h1C, r); check("R1 wthr", r, 0);
        rd(6'h20, r); check("R1 rthr", r, 0);
        rd(6'h14, r); check("R1 R4 status", r, 32'h5);
        check("R1 irq", {29'b0, irq_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 outbound order and level
        for (int i = 0; i < 3; i++) wr(6'h0C, 32'hA000_0000 + i);
        rd(6'h2C, r); check("R2 out level", r, 3);
        for (int i = 0; i < 3; i++) rpull("R2 out order", 32'hA000_0000 + i);
        rd(6'h2C, r); check("R2 out level empty", r, 0);

        // R8 overflow
        for (int i = 0; i < D; i++) wr(6'h0C, 32'hB000_0000 + i);
        rd(6'h14, r); check("R4 out full bit", r & 32'h2, 32'h2);
        wr(6'h0C, 32'hDEAD_BEEF);
        rd(6'h18, r); check("R8 error bit0", r, 1);
        rd(6'h2C, r); check("R8 level held", r, D);
        idle(1);
        rd(6'h00, r); check("R8 err state", r & 32'h4, 32'h4);
        for (int i = 0; i < D; i++) rpull("R8 dropped word absent", 32'hB000_0000 + i);
        wr(6'h00, 32'h4);
        rd(6'h18, r); check("R9 error cleared", r, 0);
        rd(6'h00, r); check("R7 err bit cleared", r & 32'h4, 0);

        // R3 inbound order, backpressure; R9 underflow
        for (int i = 0; i < D; i++) begin
            rpush(32'hC000_0000 + i, acc); check("R3 accepted", {31'b0, acc}, 1);
        end
        rpush(32'hFFFF_FFFF, acc); check("R3 ready low when full", {31'b0, acc}, 0);
        rd(6'h28, r); check("R3 in level", r, D);
        for (int i = 0; i < D; i++) begin
            rd(6'h10, r); check("R3 in order", r, 32'hC000_0000 + i);
        end
        rd(6'h10, r); check("R9 empty read zero", r, 0);
        rd(6'h18, r); check("R9 error bit1", r, 2);
        wr(6'h00, 32'h7);

        // R4 sweeps of threshold comparisons
        for (int k = 0; k <= D; k++) begin
            wr(6'h24, 32'h1);
            for (int i = 0; i < k; i++) wr(6'h0C, i);
            for (int t = 0; t <= D; t++) begin
                wr(6'h1C, t);
                rd(6'h14, r);
                check("R4 out thr bit", (r >> 2) & 1, (k <= t) ? 1 : 0);
            end
        end
        for (int k = 0; k <= D; k++) begin
            wr(6'h24, 32'h2);
            for (int i = 0; i < k; i++) rpush(i, acc);
            for (int t = 0; t <= D; t++) begin
                wr(6'h20, t);
                rd(6'h14, r);
                check("R4 in thr bit", (r >> 3) & 1, (k > t) ? 1 : 0);
            end
        end

        // R5 / R7 outbound threshold state, zero threshold, set wins
        wr(6'h24, 32'h3);
        wr(6'h1C, 0);
        idle(1);
        wr(6'h00, 32'h1);
        idle(1);
        rd(6'h00, r); check("R5 R7 bit0 held", r & 1, 1);
        wr(6'h0C, 32'h1234);
        idle(2);
        wr(6'h00, 32'h1);
        idle(1);
        rd(6'h00, r); check("R5 bit0 clear above thr", r & 1, 0);

        // R6 inbound threshold state
        wr(6'h20, 0);
        rpush(32'h55, acc);
        idle(2);
        rd(6'h00, r); check("R6 bit1 set", r & 2, 2);
        wr(6'h20, 1);
        wr(6'h00, 32'h2);
        idle(1);
        rd(6'h00, r); check("R6 bit1 clear", r & 2, 0);

        // R10 test register, R11 gating
        wr(6'h00, 32'h7);
        wr(6'h08, 32'h4);
        rd(6'h00, r); check("R10 test sets err", r, 32'h4);
        rd(6'h08, r); check("R10 test reads 0", r, 0);
        wr(6'h04, 32'h4);
        @(negedge clk); check("R11 irq enabled", {29'b0, irq_o}, 32'h4);
        wr(6'h04, 32'h3);
        @(negedge clk); check("R11 irq masked", {29'b0, irq_o}, 0);
        wr(6'h04, 0);
        wr(6'h00, 32'h4);

        // R12 flush; inbound flush vs remote offer
        wr(6'h0C, 32'h1); wr(6'h0C, 32'h2);
        wr(6'h24, 32'h1);
        rd(6'h2C, r); check("R12 out flushed", r, 0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h24; bus_wdata = 32'h2;
        in_valid = 1'b1; in_data = 32'h77;
        #1 check("R12 ready low in flush", {31'b0, in_ready}, 0);
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0; in_valid = 1'b0;
        rd(6'h28, r); check("R12 in flushed", r, 0);

        // R9 / R3 empty pop with simultaneous remote push
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 6'h10;
        in_valid = 1'b1; in_data = 32'h99;
        #1 check("R9 same-cycle pop zero", bus_rdata, 0);
        @(posedge clk); #1;
        bus_req = 1'b0; in_valid = 1'b0;
        rd(6'h28, r); check("R3 word kept", r, 1);
        rd(6'h18, r); check("R9 same-cycle error", r & 2, 2);
        rd(6'h10, r); check("R3 word value", r, 32'h99);

        // R13 write-only, unmapped, read-only writes
        rd(6'h0C, r); check("R13 txdata reads 0", r, 0);
        rd(6'h24, r); check("R13 ctrl reads 0", r, 0);
        rd(6'h30, r); check("R13 unmapped 0", r, 0);
        rpush(32'h5, acc);
        wr(6'h28, 32'h5);
        rd(6'h28, r); check("R13 level write ignored", r, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule